// File: doc/BRIEF.md
# Multi-Channel Down-Counting Interval Timer

This block is a register-mapped timer with a parameterizable number of 32-bit channels (two by default). A single-cycle strobe, `src_tick`, marks each edge of the timing source. Each channel divides that strobe by a power of two and decrements its counter once per divided tick. A channel runs either periodically, reloading its interval each time it passes zero, or as a one-shot that halts at zero and clears its own enable. A channel loaded with an all-ones interval in periodic mode acts as a free-running time base.

Software uses a plain synchronous bus: address, write enable and write data, with read data returned combinationally for the presented address. A shared enable mask and a write-one-to-clear status word drive one interrupt line. A channel that is switched off does not stop at once. It keeps counting through the next two source ticks and halts only after them. Software is expected to wait three ticks before it reprograms that channel.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: The interrupt-enable mask is at offset 0x00 and the status word at 0x04, one bit per channel. Channel n has its control register at 0x10*n+0x10, its interval register at 0x10*n+0x14 and its count register at 0x10*n+0x18. Any other offset reads zero, and a write to it changes nothing.
- R3: Control register layout: bit 7 one-shot (0 = periodic), bits 6:4 prescaler, bits 3:2 source select (stored only), bit 1 reload, bit 0 enable. Reload always reads 0, and bits 31:8 read 0.
- R4: A control write with bit 1 set copies the interval register into the count register, and the new count is visible one clock later.
- R5: While running, the count drops by one on each divided tick. With prescaler p there is one divided tick per 2^p source ticks, counted from the last reload write.
- R6: In periodic mode, a divided tick that finds the count at zero reloads it from the interval register.
- R7: In one-shot mode, the divided tick that brings the count to zero also clears the enable bit, and the count then holds at zero.
- R8: A channel's status bit is set on any divided tick where its count goes from 1 to 0, in either mode.
- R9: Writing 1 to a status bit clears it and writing 0 leaves it. A set from a channel in the same cycle takes priority over the clear.
- R10: `irq` is high exactly when some channel has both its status bit and its enable-mask bit set.
- R11: After enable is cleared on a running channel, the channel still counts on the next two source ticks and is halted from then on. Setting enable again before that cancels the halt.
- R12: The interval register reads back what was last written to it. Writes to the count register are ignored.
- R13: A source tick that arrives in the same cycle as a control write to a channel is not counted by that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_tick | input | 1 | One-cycle strobe per edge of the timing source |
| bus_addr | input | ADDR_W (8) | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request, level |

## Verification
The assertions assume there is at most one bus access per cycle, that `src_tick` is high for one cycle per source edge and is synchronous to `clk`, and that status clears come only through word writes to offset 0x04. The stimulus keeps to these assumptions because it drives exactly one access per clock from a task, and it raises the tick for a whole cycle chosen by `$urandom`. The random phase writes small intervals and prescalers of 0 to 2, so that wraps, one-shot stops, status sets and clears occur often. The directed part covers the disable drain, reload, the collision between a write and a tick, and the unmapped offsets.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  localparam int DATA_W   = 32;
  localparam int PRE_W    = 3;

  // register offsets
  localparam int OFS_IE    = 'h00;
  localparam int OFS_ST    = 'h04;
  localparam int CH_BASE   = 'h10;
  localparam int CH_STRIDE = 'h10;
  localparam int SUB_CTRL  = 'h0;
  localparam int SUB_INTV  = 'h4;
  localparam int SUB_CNT   = 'h8;

  // control bit positions
  localparam int CTL_EN  = 0;
  localparam int CTL_RLD = 1;
  localparam int CTL_SRC = 2;
  localparam int CTL_PRE = 4;
  localparam int CTL_OS  = 7;

  typedef struct packed {
    logic             oneshot;
    logic [PRE_W-1:0] pre;
    logic [1:0]       src;
    logic             en;
  } chan_cfg_t;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic             src_tick,
  input  logic [SEL_W-1:0] sel,
  output logic             div_tick
);
  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] cnt_q, cnt_d, mask;
  logic             step;

  always_comb begin
    for (int i = 0; i < DIV_W; i++) mask[i] = (i < int'(sel));
  end

  assign step     = src_tick & run;
  assign div_tick = step & ((cnt_q & mask) == mask);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (step) cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tick_timer_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int DRAIN_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_tick,
  input  logic              ctrl_we,
  input  logic              intv_we,
  input  logic [DATA_W-1:0] wdata,
  output chan_cfg_t         cfg_o,
  output logic [CNT_W-1:0]  intv_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              zero_hit
);
  localparam int DRN_W = $clog2(DRAIN_TICKS + 1);

  chan_cfg_t        cfg_q, cfg_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, intv_q, intv_d;
  logic             act_q, act_d;
  logic [DRN_W-1:0] drn_q, drn_d;
  logic             pclr, dtick, hit;

  tmr_prescaler #(.SEL_W(PRE_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (pclr),
    .run      (act_q),
    .src_tick (src_tick),
    .sel      (cfg_q.pre),
    .div_tick (dtick)
  );

  assign pclr = ctrl_we & wdata[CTL_RLD];

  always_comb begin
    cfg_d  = cfg_q;
    cnt_d  = cnt_q;
    intv_d = intv_q;
    act_d  = act_q;
    drn_d  = drn_q;
    hit    = 1'b0;
    if (intv_we) intv_d = wdata[CNT_W-1:0];
    if (ctrl_we) begin
      cfg_d.en      = wdata[CTL_EN];
      cfg_d.src     = wdata[CTL_SRC +: 2];
      cfg_d.pre     = wdata[CTL_PRE +: PRE_W];
      cfg_d.oneshot = wdata[CTL_OS];
      if (wdata[CTL_RLD]) cnt_d = intv_q;
      if (wdata[CTL_EN]) begin
        act_d = 1'b1;
        drn_d = '0;
      end else if (act_q && drn_q == '0) begin
        drn_d = DRN_W'(DRAIN_TICKS);
      end
    end else begin
      if (dtick) begin
        if (cnt_q == CNT_W'(1)) hit = 1'b1;
        if (cfg_q.oneshot && cnt_q <= CNT_W'(1)) begin
          cnt_d    = '0;
          cfg_d.en = 1'b0;
          act_d    = 1'b0;
          drn_d    = '0;
        end else if (cnt_q == '0) begin
          cnt_d = intv_q;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      if (src_tick && drn_q != '0 && act_d) begin
        if (drn_q == DRN_W'(1)) act_d = 1'b0;
        drn_d = drn_q - DRN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      cnt_q  <= '0;
      intv_q <= '0;
      act_q  <= 1'b0;
      drn_q  <= '0;
    end else begin
      cfg_q  <= cfg_d;
      cnt_q  <= cnt_d;
      intv_q <= intv_d;
      act_q  <= act_d;
      drn_q  <= drn_d;
    end
  end

  assign cfg_o    = cfg_q;
  assign intv_o   = intv_q;
  assign count_o  = cnt_q;
  assign zero_hit = hit;

  // R4: reload write lands the interval in the counter
  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && wdata[CTL_RLD]) |=> (cnt_q == $past(intv_q)));

  // R5: running count drops by exactly one per divided tick
  p_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dtick && !ctrl_we && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R7: one-shot stop clears enable and parks at zero
  p_oneshot_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dtick && !ctrl_we && cfg_q.oneshot && cnt_q == CNT_W'(1)) |=> (!cfg_q.en && cnt_q == '0));

  // R11: a halted channel never moves on its own
  p_halted_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q && !ctrl_we) |=> $stable(cnt_q));

  // R11: running with enable low is only allowed inside the drain window
  p_drain_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !cfg_q.en) |-> (drn_q != '0));

endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
  import tick_timer_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int ADDR_W      = 8,
  parameter int CNT_W       = 32,
  parameter int DRAIN_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_IE = ADDR_W'(OFS_IE);
  localparam logic [ADDR_W-1:0] A_ST = ADDR_W'(OFS_ST);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic [NCH-1:0]   ie_q, ie_d, st_q, st_d, hit, ctrl_we, intv_we, st_clr;
  chan_cfg_t        cfg  [NCH];
  logic [CNT_W-1:0] intv [NCH];
  logic [CNT_W-1:0] cnt  [NCH];

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CH_BASE + CH_STRIDE * c + SUB_CTRL);
      localparam logic [ADDR_W-1:0] A_INTV = ADDR_W'(CH_BASE + CH_STRIDE * c + SUB_INTV);

      assign ctrl_we[c] = bus_we && (bus_addr == A_CTRL);
      assign intv_we[c] = bus_we && (bus_addr == A_INTV);

      tmr_channel #(
        .CNT_W       (CNT_W),
        .DRAIN_TICKS (DRAIN_TICKS)
      ) u_ch (
        .clk      (clk),
        .rst_n    (rst_i_n),
        .src_tick (src_tick),
        .ctrl_we  (ctrl_we[c]),
        .intv_we  (intv_we[c]),
        .wdata    (bus_wdata),
        .cfg_o    (cfg[c]),
        .intv_o   (intv[c]),
        .count_o  (cnt[c]),
        .zero_hit (hit[c])
      );

      // R8: a 1->0 step always leaves the status bit set
      p_status_set_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
        hit[c] |=> st_q[c]);

      // R9: write-one-to-clear takes effect when no new event races it
      p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
        (bus_we && bus_addr == A_ST && bus_wdata[c] && !hit[c]) |=> !st_q[c]);
    end
  endgenerate

  assign st_clr = (bus_we && bus_addr == A_ST) ? bus_wdata[NCH-1:0] : '0;

  always_comb begin
    ie_d = ie_q;
    if (bus_we && bus_addr == A_IE) ie_d = bus_wdata[NCH-1:0];
    st_d = (st_q & ~st_clr) | hit;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ie_q <= '0;
      st_q <= '0;
    end else begin
      ie_q <= ie_d;
      st_q <= st_d;
    end
  end

  assign irq = |(st_q & ie_q);

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_IE) bus_rdata = DATA_W'(ie_q);
    if (bus_addr == A_ST) bus_rdata = DATA_W'(st_q);
    for (int c = 0; c < NCH; c++) begin
      if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * c + SUB_CTRL))
        bus_rdata = DATA_W'({cfg[c].oneshot, cfg[c].pre, cfg[c].src, 1'b0, cfg[c].en});
      if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * c + SUB_INTV))
        bus_rdata = DATA_W'(intv[c]);
      if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * c + SUB_CNT))
        bus_rdata = DATA_W'(cnt[c]);
    end
  end

  // R10: no interrupt without an enabled pending channel
  p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    irq |-> ((st_q & ie_q) != '0));

endmodule

// File: tb/tick_timer_bank_test.sv
module tick_timer_bank_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        src_tick = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  tick_timer_bank uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_tick  (src_tick),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  // model of the requirements, two channels
  logic        m_en [2], m_os [2], m_act [2];
  logic [1:0]  m_src [2];
  logic [2:0]  m_pre [2];
  logic [31:0] m_cnt [2], m_intv [2];
  int unsigned m_pc [2], m_drn [2];
  logic [1:0]  m_ie, m_st;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [7:0] a);
    logic [31:0] r = 32'h0;
    if (a == 8'h00) r = {30'h0, m_ie};
    if (a == 8'h04) r = {30'h0, m_st};
    for (int c = 0; c < 2; c++) begin
      if (a == 8'(16 + 16 * c)) r = {24'h0, m_os[c], m_pre[c], m_src[c], 1'b0, m_en[c]};
      if (a == 8'(20 + 16 * c)) r = m_intv[c];
      if (a == 8'(24 + 16 * c)) r = m_cnt[c];
    end
    return r;
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    if (a == 8'h00 || a == 8'h04) return "R9";
    if (a == 8'h10 || a == 8'h20) return "R3";
    if (a == 8'h14 || a == 8'h24) return "R12";
    if (a == 8'h18 || a == 8'h28) return "R5";
    return "R2";
  endfunction

  task automatic m_step(input logic [7:0] a, input logic we, input logic [31:0] wd, input logic tk);
    logic [1:0] hits = 2'b00;
    for (int c = 0; c < 2; c++) begin
      logic        cw = we && a == 8'(16 + 16 * c);
      logic        iw = we && a == 8'(20 + 16 * c);
      int unsigned mask = (32'd1 << m_pre[c]) - 1;
      logic        dt = tk && m_act[c] && ((m_pc[c] & mask) == mask);
      logic [31:0] old_iv = m_intv[c];
      if (cw && wd[1])          m_pc[c] = 0;
      else if (tk && m_act[c])  m_pc[c] = (m_pc[c] + 1) & 127;
      if (iw) m_intv[c] = wd;
      if (cw) begin
        m_en[c] = wd[0]; m_src[c] = wd[3:2]; m_pre[c] = wd[6:4]; m_os[c] = wd[7];
        if (wd[1]) m_cnt[c] = old_iv;
        if (wd[0]) begin m_act[c] = 1'b1; m_drn[c] = 0; end
        else if (m_act[c] && m_drn[c] == 0) m_drn[c] = 2;
      end else begin
        if (dt) begin
          if (m_cnt[c] == 1) hits[c] = 1'b1;
          if (m_os[c] && m_cnt[c] <= 1) begin
            m_cnt[c] = 0; m_en[c] = 1'b0; m_act[c] = 1'b0; m_drn[c] = 0;
          end else if (m_cnt[c] == 0) m_cnt[c] = old_iv;
          else m_cnt[c] = m_cnt[c] - 1;
        end
        if (tk && m_drn[c] != 0 && m_act[c]) begin
          if (m_drn[c] == 1) m_act[c] = 1'b0;
          m_drn[c] = m_drn[c] - 1;
        end
      end
    end
    if (we && a == 8'h04) m_st = m_st & ~wd[1:0];
    m_st = m_st | hits;
    if (we && a == 8'h00) m_ie = wd[1:0];
  endtask

  // read with check; the tick given is applied in the same cycle
  task automatic rd(input logic [7:0] a, input logic tk, input string req, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0; bus_wdata = 32'h0; src_tick = tk;
    #1;
    v = bus_rdata;
    chk(bus_rdata, m_read(a), req);
    chk({31'h0, irq}, {31'h0, |(m_st & m_ie)}, "R10");
    m_step(a, 1'b0, 32'h0, tk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic tk);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d; src_tick = tk;
    m_step(a, 1'b1, d, tk);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, v0;
    logic [7:0]  alist [12];
    alist = '{8'h00, 8'h04, 8'h08, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h24, 8'h28, 8'h30, 8'h11};
    for (int c = 0; c < 2; c++) begin
      m_en[c] = 0; m_os[c] = 0; m_act[c] = 0; m_src[c] = 0; m_pre[c] = 0;
      m_cnt[c] = 0; m_intv[c] = 0; m_pc[c] = 0; m_drn[c] = 0;
    end
    m_ie = 0; m_st = 0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset values
    foreach (alist[i]) rd(alist[i], 1'b0, "R1", v);

    // R2: unmapped writes are ignored
    wr(8'h08, 32'hFFFF_FFFF, 1'b0);
    wr(8'h1C, 32'hFFFF_FFFF, 1'b0);
    wr(8'h30, 32'hFFFF_FFFF, 1'b0);
    wr(8'h15, 32'hFFFF_FFFF, 1'b0);
    foreach (alist[i]) rd(alist[i], 1'b0, "R2", v);

    // R3, R4, R12: program channel 0 periodic, interval 2
    wr(8'h14, 32'd2, 1'b0);
    wr(8'h18, 32'h55, 1'b0);
    rd(8'h18, 1'b0, "R12", v);
    wr(8'h10, 32'h0000_000F, 1'b0);
    rd(8'h10, 1'b0, "R3", v);
    chk(v, 32'h0000_000D, "R3");
    rd(8'h18, 1'b0, "R4", v);
    chk(v, 32'd2, "R4");
    wr(8'h00, 32'h3, 1'b0);

    // R5, R6, R8, R10: ticks every cycle, watch wrap and status
    for (int i = 0; i < 8; i++) rd(8'h18, 1'b1, "R6", v);
    rd(8'h04, 1'b0, "R8", v);
    chk(v[0], 1'b1, "R8");
    // R9: clear status, with ticks paused
    wr(8'h04, 32'h1, 1'b0);
    rd(8'h04, 1'b0, "R9", v);
    chk(v, 32'h0, "R9");

    // R7: channel 1 one-shot, prescaler 2, interval 3
    wr(8'h24, 32'd3, 1'b0);
    wr(8'h20, 32'h0000_00A3, 1'b0);
    for (int i = 0; i < 20; i++) rd(8'h28, 1'b1, "R7", v);
    chk(v, 32'h0, "R7");
    rd(8'h20, 1'b0, "R7", v);
    chk(v[0], 1'b0, "R7");
    rd(8'h04, 1'b0, "R8", v);

    // R11: disable drains two source ticks
    wr(8'h14, 32'd100, 1'b0);
    wr(8'h10, 32'h3, 1'b0);
    rd(8'h18, 1'b1, "R11", v);
    wr(8'h10, 32'h0, 1'b0);
    rd(8'h18, 1'b1, "R11", v0);
    rd(8'h18, 1'b1, "R11", v);
    rd(8'h18, 1'b1, "R11", v);
    rd(8'h18, 1'b1, "R11", v);
    chk(v, v0 - 32'd2, "R11");

    // R13: tick colliding with a control write is dropped
    wr(8'h10, 32'h3, 1'b0);
    rd(8'h18, 1'b0, "R13", v0);
    wr(8'h10, 32'h1, 1'b1);
    rd(8'h18, 1'b0, "R13", v);
    chk(v, v0, "R13");

    // R12: count register not writable
    wr(8'h18, 32'h1234, 1'b0);
    rd(8'h18, 1'b0, "R12", v);
    chk(v, v0, "R12");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [7:0]  a  = alist[$urandom % 12];
      logic        tk = 1'($urandom % 2);
      logic [31:0] d  = $urandom;
      if (($urandom % 10) < 3) begin
        if (a == 8'h10 || a == 8'h20) d = {24'h0, d[7], 3'($urandom % 3), d[3:0]};
        else if (a == 8'h14 || a == 8'h24) d = $urandom % 13;
        wr(a, d, tk);
      end else begin
        rd(a, tk, tag_of(a), v);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule